// File: doc/BRIEF.md
# I2C Serial Memory Target with Address Pointer

This block is the bus-facing front end of a byte-wide serial memory that answers as a target on a two-wire I2C bus. It watches clock and data lines that have already been synchronized into the system clock domain. It detects START and STOP conditions and checks each control byte against a fixed device-type tag and three strapped select bits. It acknowledges a byte by pulling the data line low through an open-drain output enable.

One address pointer is kept across transactions and is used by both directions. A write-type transaction loads it from two address bytes, and any data bytes that follow are stored at the pointer. A read-type transaction returns bytes from the pointer for as long as the bus master acknowledges them. A random read is a write-type transaction that carries only the address and is cut short by a repeated START, followed by a read-type control byte. A small synchronous byte RAM stands in for the storage array.

Top module: `i2c_mem_reader`

## Requirements
- R1: The target answers a control byte only when its bits [7:4] equal 4'b1010 and its bits [3:1] equal `dev_sel_i`. Any other control byte gets no acknowledge, leaves the pointer unchanged, and is ignored until the next START.
- R2: The target acknowledges an accepted control byte, both address bytes and every written data byte. It does this by asserting `sda_oe_o` during the ninth clock.
- R3: In a write-type transaction (control bit 0 = 0), the first address byte supplies pointer bits [12:8] from its bits [4:0], and its bits [7:5] are ignored. The second byte supplies pointer bits [7:0]. Each following data byte is stored at the pointer, and the pointer then advances by one.
- R4: A read-type transaction (control bit 0 = 1) that is not preceded by an address returns the byte at the current pointer. After any access to address n, the pointer is n+1.
- R5: A repeated START after the second address byte keeps the loaded pointer and writes nothing. A following read returns the data at the loaded address.
- R6: A master acknowledge (data low on the ninth clock) after a read byte makes the target send the next byte. A master NACK ends the read, and the target releases the data line.
- R7: The pointer advances by exactly one per completed data byte and wraps from 0x1FFF to 0x0000.
- R8: A START in the middle of a byte returns the target to the control-byte phase. A STOP in the middle of a byte returns it to idle. Neither changes the pointer nor writes the array.
- R9: Read data leaves the target most significant bit first. `sda_oe_o` is only asserted while SCL is low.
- R10: After reset, `sda_oe_o` is 0 and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line, as seen on the wire |
| dev_sel_i | input | 3 | Strapped device-select value |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |

## Verification
Several behaviours are checked by assertions on every cycle. The data-line driver is only switched on while SCL is low. Any change of the pointer other than an address load is a step of exactly one, modulo the array size. A START always lands in the control phase, and a STOP always lands in idle with the line released. The driver is active only in acknowledge or transmit states, and the control acknowledge state is reached only after a matching control byte. The bench scenarios are needed to show the end-to-end effects. These are the data returned for current-address, random and burst reads, the wrap at the top of the array, and the rejection of foreign control bytes. They also show that aborted bytes neither write the array nor move the pointer, and that the pointer returns to zero after reset.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam logic [3:0] CTRL_TAG = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RDAT_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    // data moves while the clock stays high: framing conditions
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_oe_o
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        tgt_state_e        st;
        logic [7:0]        sr;
        logic [3:0]        cnt;
        logic [HI_W-1:0]   hi;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              oe;
        logic [7:0]        tx;
    } ctx_t;

    ctx_t q, d;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic we;
    logic [7:0] rdata;

    i2c_line_events u_ev (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_byte_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (q.ptr),
        .wdata_i (q.sr),
        .raddr_i (q.ptr),
        .rdata_o (rdata)
    );

    always_comb begin
        d  = q;
        we = 1'b0;
        if (stop_det) begin
            d.st  = S_IDLE;
            d.oe  = 1'b0;
            d.cnt = 4'd0;
        end else if (start_det) begin
            d.st  = S_CTRL;
            d.oe  = 1'b0;
            d.cnt = 4'd0;
        end else begin
            case (q.st)
                S_CTRL, S_AHI, S_ALO, S_WDAT: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sr  = {q.sr[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        d.oe  = 1'b1;
                        case (q.st)
                            S_CTRL: begin
                                if (q.sr[7:4] == CTRL_TAG && q.sr[3:1] == dev_sel_i) begin
                                    d.rw = q.sr[0];
                                    d.st = S_CTRL_ACK;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = S_IDLE;
                                end
                            end
                            S_AHI: begin
                                d.hi = q.sr[HI_W-1:0];
                                d.st = S_AHI_ACK;
                            end
                            S_ALO: begin
                                d.ptr = {q.hi, q.sr};
                                d.st  = S_ALO_ACK;
                            end
                            default: begin
                                we    = 1'b1;
                                d.ptr = q.ptr + ADDR_W'(1);
                                d.st  = S_WDAT_ACK;
                            end
                        endcase
                    end
                end
                S_CTRL_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK: begin
                    if (scl_fall) begin
                        d.cnt = 4'd0;
                        if (q.st == S_CTRL_ACK && q.rw) begin
                            d.tx = rdata;
                            d.oe = ~rdata[7];
                            d.st = S_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            case (q.st)
                                S_CTRL_ACK: d.st = S_AHI;
                                S_AHI_ACK:  d.st = S_ALO;
                                default:    d.st = S_WDAT;
                            endcase
                        end
                    end
                end
                S_RDAT: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + ADDR_W'(1);
                            d.cnt = 4'd0;
                            d.st  = S_RDAT_ACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                S_RDAT_ACK: begin
                    if (scl_rise) begin
                        d.sr[0] = sda_i;
                    end else if (scl_fall) begin
                        if (!q.sr[0]) begin
                            d.tx = rdata;
                            d.oe = ~rdata[7];
                            d.st = S_RDAT;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= S_IDLE;
            q.sr  <= '0;
            q.cnt <= '0;
            q.hi  <= '0;
            q.ptr <= '0;
            q.rw  <= 1'b0;
            q.oe  <= 1'b0;
            q.tx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    tgt_state_e        st_q;
    logic [ADDR_W-1:0] ptr_q;
    assign st_q  = q.st;
    assign ptr_q = q.ptr;

    // R9: the line is only grabbed while the clock is low
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R7: apart from an address load, the pointer only steps by one (with wrap)
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) && ($past(st_q) != S_ALO)
        |-> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)));

    // R8: framing conditions steer the state machine
    p_start_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> st_q == S_CTRL);
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st_q == S_IDLE) && !sda_oe_o);

    // R2: the driver is active only in acknowledge or transmit states
    p_oe_states_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (st_q inside {S_CTRL_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK, S_RDAT}));

    // R1: a control acknowledge follows only a matching control byte
    p_ctrl_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CTRL_ACK) |-> (q.sr[7:4] == CTRL_TAG) && (q.sr[3:1] == dev_sel_i));

endmodule

// File: tb/i2c_mem_reader_test.sv
module i2c_mem_reader_test;
    localparam int AW = 13;
    localparam int QP = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       m_scl;
    logic       m_sda;
    logic [2:0] sel;
    logic       oe;
    logic       sda_bus;

    assign sda_bus = m_sda & ~oe;

    i2c_mem_reader #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .dev_sel_i (sel),
        .sda_oe_o  (oe)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]    mdl [0:(1<<AW)-1];
    bit            vld [0:(1<<AW)-1];
    logic [AW-1:0] mptr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_byte(input logic [2:0] s, input bit rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic qw;
        repeat (QP) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b0; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b1; qw;
    endtask

    task automatic send_bit(input bit b);
        m_sda = b; qw;
        m_scl = 1'b1; qw; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        acked = !sda_bus; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw;
            m_scl = 1'b1; qw;
            b[i] = sda_bus; qw;
            m_scl = 1'b0; qw;
        end
        send_bit(!mack);
    endtask

    // R4 / R6: read body after a START; pointer model follows every byte
    task automatic read_body(input int n, input string tag);
        bit a;
        logic [7:0] b;
        send_byte(ctrl_byte(sel, 1'b1), a);
        chk(a, "R2 read control ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            if (vld[mptr]) chk(b === mdl[mptr], tag, b, mdl[mptr]);
            mptr = mptr + 1'b1;
        end
        bus_stop;
        chk(oe == 1'b0, "R6 line released after NACK", oe, 0);
    endtask

    task automatic send_addr(input logic [AW-1:0] addr);
        bit a;
        send_byte(ctrl_byte(sel, 1'b0), a);
        chk(a, "R2 write control ack", a, 1);
        send_byte({3'b111, addr[12:8]}, a);
        chk(a, "R2 high address ack", a, 1);
        send_byte(addr[7:0], a);
        chk(a, "R2 low address ack", a, 1);
        mptr = addr;
    endtask

    // R3: write burst
    task automatic do_write(input logic [AW-1:0] addr, input int n);
        bit a;
        logic [7:0] v;
        bus_start;
        send_addr(addr);
        for (int k = 0; k < n; k++) begin
            v = 8'($urandom);
            send_byte(v, a);
            chk(a, "R3 data byte ack", a, 1);
            mdl[mptr] = v;
            vld[mptr] = 1'b1;
            mptr = mptr + 1'b1;
        end
        bus_stop;
    endtask

    // R5: dummy write then repeated START
    task automatic random_read(input logic [AW-1:0] addr, input int n);
        bus_start;
        send_addr(addr);
        bus_start;
        read_body(n, "R5 random read data");
    endtask

    task automatic current_read(input int n, input string tag);
        bus_start;
        read_body(n, tag);
    endtask

    initial begin
        bit a;
        void'($urandom(32'd1234));
        m_scl = 1'b1;
        m_sda = 1'b1;
        sel   = 3'b101;
        rst_n = 1'b0;
        for (int i = 0; i < (1 << AW); i++) vld[i] = 1'b0;
        repeat (4) @(negedge clk);
        chk(oe == 1'b0, "R10 reset output enable", oe, 0);
        rst_n = 1'b1;
        qw;

        // R10: pointer returns to zero after a second reset
        do_write(13'h0000, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mptr = '0;
        qw;
        current_read(1, "R10 pointer zero after reset");

        // R7: write and read across the top of the array
        do_write(13'h1FFC, 8);
        random_read(13'h1FFE, 4);
        chk(mptr == 13'h0002, "R7 wrap pointer model", mptr, 2);

        // R4: current-address read continues at n+1
        current_read(1, "R4 current address data");

        // R3: fill a working window
        do_write(13'h0100, 32);
        random_read(13'h0100, 6);
        current_read(3, "R6 sequential continuation");

        // R1: foreign select bits and foreign tag are not acknowledged
        bus_start;
        send_byte(ctrl_byte(sel ^ 3'b001, 1'b1), a);
        chk(!a, "R1 foreign select nack", a, 0);
        bus_stop;
        bus_start;
        send_byte({4'b1011, sel, 1'b1}, a);
        chk(!a, "R1 foreign tag nack", a, 0);
        bus_stop;
        current_read(1, "R1 pointer untouched by foreign byte");

        // R8: START inside the low address byte keeps the pointer
        bus_start;
        begin
            send_byte(ctrl_byte(sel, 1'b0), a);
            send_byte(8'h01, a);
            send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        end
        bus_start;
        read_body(1, "R8 pointer kept after START abort");

        // R8: STOP inside a data byte writes nothing
        bus_start;
        send_addr(13'h0105);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop;
        current_read(1, "R8 no write after STOP abort");

        // constrained random mix inside the window
        for (int it = 0; it < 25; it++) begin
            int kind;
            kind = $urandom_range(0, 2);
            if (kind == 0) begin
                random_read(13'h0100 + 13'($urandom_range(0, 24)), $urandom_range(1, 6));
            end else if (kind == 1) begin
                current_read($urandom_range(1, 4), "R9 current read data msb first");
            end else begin
                do_write(13'h0100 + 13'($urandom_range(0, 28)), $urandom_range(1, 3));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule